// File: doc/BRIEF.md
# Descriptor Completion Notification Unit

This unit sits beside one processing channel and decides how the host is told that a descriptor has finished, and what the channel does after a fault. It watches a completion event and an error event, both raised while a descriptor is active. It also takes the header that was fetched for that descriptor and an integrity-check request flag with its comparison outcome. From these it raises level interrupts and issues a request to write the header back. Where a fault occurs it either lets the channel move on or stops it until the host steps in.

Configuration inputs select the notification scheme. A completion interrupt can fire for every descriptor or only for those whose header sets a notify bit. A header writeback can happen for every descriptor or only for those that asked for an integrity check. A failed integrity check can be treated as a fault, and a fault can either skip to the next descriptor or halt. The unit accepts a new event only while `desc_ready` is high. That signal drops while a writeback waits for its handshake and while the channel is halted.

Top module: `desc_notify`

## Requirements
- R1: After reset `irq_done`, `irq_err`, `wb_valid` and `halted` are 0 and `desc_ready` is 1.
- R2: With `cfg_done_irq`=1, an accepted `desc_done` without a fault sets `irq_done` on the next cycle. This happens when `cfg_irq_all`=1, or when header bit 0 (the notify bit) is 1. With `cfg_done_irq`=0, `irq_done` stays 0.
- R3: The writeback word equals the accepted header except for two fields. Bits 63:56 are forced to 8'hFF. When `icv_req`=1, bits 15:8 carry the check status: 8'h00 for a pass and 8'h01 for a mismatch (`icv_fail`=1). When `icv_req`=0, bits 15:8 are copied unchanged.
- R4: A fault-free completion starts a writeback when `cfg_wb_en`=1 and either `cfg_wb_all`=1 or `icv_req`=1. Otherwise no writeback starts.
- R5: `wb_valid` rises on the cycle after the accepting edge. It then holds with `wb_data` stable, and `desc_ready` stays 0, until an edge that sees `wb_ready`=1. After that edge `wb_valid` is 0 and `desc_ready` is 1.
- R6: An accepted `err_evt` sets `irq_err` whatever the configuration. It starts no writeback and no completion interrupt, and it takes priority over a `desc_done` in the same cycle.
- R7: When `cfg_icv_irq`=1, a completion with `icv_req`=1 and `icv_fail`=1 is a fault. It behaves as in R6. A fail flag without `icv_req` is not a fault.
- R8: After a fault with `cfg_halt`=1, `halted` is 1 and `desc_ready` is 0 until a `host_resume` pulse. With `cfg_halt`=0 the unit stays ready.
- R9: `irq_done` and `irq_err` stay at 1 until an edge that sees `host_ack_done` or `host_ack_err` respectively. A new set in that same cycle wins over the acknowledge.
- R10: Events while `desc_ready`=0 are ignored. `host_resume` while not halted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_done_irq | input | 1 | enable completion interrupt |
| cfg_irq_all | input | 1 | 1: interrupt on every descriptor, 0: only when the notify bit is set |
| cfg_icv_irq | input | 1 | treat an integrity mismatch as a fault |
| cfg_wb_en | input | 1 | enable header writeback |
| cfg_wb_all | input | 1 | 1: write back every descriptor, 0: only check-requesting ones |
| cfg_halt | input | 1 | 1: halt on fault, 0: continue |
| hdr_in | input | 64 | header of the active descriptor |
| desc_done | input | 1 | completion event pulse |
| icv_req | input | 1 | descriptor requested an integrity check |
| icv_fail | input | 1 | integrity comparison mismatched |
| err_evt | input | 1 | channel or unit error pulse |
| host_ack_done | input | 1 | clears `irq_done` |
| host_ack_err | input | 1 | clears `irq_err` |
| host_resume | input | 1 | leaves the halted state |
| wb_ready | input | 1 | writeback sink accepts |
| desc_ready | output | 1 | unit can accept an event |
| irq_done | output | 1 | completion interrupt level |
| irq_err | output | 1 | error interrupt level |
| wb_valid | output | 1 | writeback request |
| wb_data | output | 64 | header to write back |
| halted | output | 1 | channel halted after fault |

## Verification
The bench targets the interplay of an error interrupt with an enabled writeback. A design that lets the writeback through would show `wb_valid` after a mismatch or error. It also covers a fail flag without a check request, which a careless decoder would turn into a fault or a nonzero status. Header fields are checked bit for bit against a separately built image, so a wrong byte forced or a lost status would differ. Events and acknowledges arriving while halted or while a writeback stalls are also driven, where a wrong gate would raise interrupts or drop the held data.

// File: rtl/desc_notify.sv
module desc_notify #(
  parameter int HDR_W      = 64,
  parameter int DONE_W     = 8,
  parameter int NOTIFY_POS = 0,
  parameter int STAT_LSB   = 8,
  parameter int STAT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_done_irq,
  input  logic             cfg_irq_all,
  input  logic             cfg_icv_irq,
  input  logic             cfg_wb_en,
  input  logic             cfg_wb_all,
  input  logic             cfg_halt,
  input  logic [HDR_W-1:0] hdr_in,
  input  logic             desc_done,
  input  logic             icv_req,
  input  logic             icv_fail,
  input  logic             err_evt,
  input  logic             host_ack_done,
  input  logic             host_ack_err,
  input  logic             host_resume,
  input  logic             wb_ready,
  output logic             desc_ready,
  output logic             irq_done,
  output logic             irq_err,
  output logic             wb_valid,
  output logic [HDR_W-1:0] wb_data,
  output logic             halted
);
  localparam int DONE_LSB = HDR_W - DONE_W;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_HALT} st_t;
  st_t state;

  logic fault, fin, want_wb, want_irq;
  logic [STAT_W-1:0] stat;
  logic [HDR_W-1:0]  wb_next;

  assign desc_ready = (state == S_IDLE);
  assign wb_valid   = (state == S_WB);
  assign halted     = (state == S_HALT);

  assign fault    = err_evt | (desc_done & icv_req & icv_fail & cfg_icv_irq);
  assign fin      = desc_done & ~fault;
  assign want_wb  = fin & cfg_wb_en & (cfg_wb_all | icv_req);
  assign want_irq = fin & cfg_done_irq & (cfg_irq_all | hdr_in[NOTIFY_POS]);
  assign stat     = icv_req ? {{(STAT_W-1){1'b0}}, icv_fail} : hdr_in[STAT_LSB +: STAT_W];

  always_comb begin
    wb_next = hdr_in;
    wb_next[DONE_LSB +: DONE_W] = '1;
    wb_next[STAT_LSB +: STAT_W] = stat;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
      wb_data  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (fault) begin
            state <= cfg_halt ? S_HALT : S_IDLE;
          end else if (want_wb) begin
            state   <= S_WB;
            wb_data <= wb_next;
          end
        end
        S_WB:    if (wb_ready) state <= S_IDLE;
        S_HALT:  if (host_resume) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      irq_done <= (desc_ready & want_irq) | (irq_done & ~host_ack_done);
      irq_err  <= (desc_ready & fault)    | (irq_err  & ~host_ack_err);
    end
  end
endmodule

module desc_notify_chk #(
  parameter int HDR_W  = 64,
  parameter int DONE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             desc_ready,
  input logic             host_ack_done,
  input logic             host_ack_err,
  input logic             host_resume,
  input logic             halted,
  input logic             irq_done,
  input logic             irq_err,
  input logic             wb_valid,
  input logic             wb_ready,
  input logic [HDR_W-1:0] wb_data
);
  assert_done_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_data[HDR_W-1 -: DONE_W] == '1);

  assert_wb_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_data) && !desc_ready));

  assert_err_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_err) |-> !wb_valid);

  assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !host_resume) |=> halted);

  assert_done_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_done && !host_ack_done) |=> irq_done);

  assert_err_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_err && !host_ack_err) |=> irq_err);

  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_ready && !irq_done) |=> !irq_done);
endmodule

bind desc_notify desc_notify_chk #(.HDR_W(HDR_W), .DONE_W(DONE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_ready(desc_ready), .host_ack_done(host_ack_done),
  .host_ack_err(host_ack_err), .host_resume(host_resume), .halted(halted),
  .irq_done(irq_done), .irq_err(irq_err), .wb_valid(wb_valid),
  .wb_ready(wb_ready), .wb_data(wb_data)
);

// File: tb/tb_desc_notify.sv
module tb_desc_notify;
  logic clk = 0, rst_n = 0;
  logic cfg_done_irq = 0, cfg_irq_all = 0, cfg_icv_irq = 0, cfg_wb_en = 0, cfg_wb_all = 0, cfg_halt = 0;
  logic [63:0] hdr_in = '0;
  logic desc_done = 0, icv_req = 0, icv_fail = 0, err_evt = 0;
  logic host_ack_done = 0, host_ack_err = 0, host_resume = 0, wb_ready = 0;
  logic desc_ready, irq_done, irq_err, wb_valid, halted;
  logic [63:0] wb_data;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  desc_notify dut (.*);

  // {done_irq,irq_all,icv_irq,wb_en,wb_all,halt, notify,icv_req,icv_fail,err, e_done,e_err,e_wb,e_halt}
  localparam logic [13:0] VEC [14] = '{
    14'b110000_0000_1000,
    14'b100000_0000_0000,
    14'b100000_1000_1000,
    14'b000110_0000_0010,
    14'b000100_0000_0000,
    14'b000100_0100_0010,
    14'b000100_0110_0010,
    14'b111110_0110_0100,
    14'b111111_0110_0101,
    14'b110110_0001_0100,
    14'b000001_0001_0101,
    14'b101100_1100_1010,
    14'b000000_1000_0000,
    14'b001110_0010_0010
  };

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] expect_wb(input logic [63:0] h, input logic rq, input logic fl);
    logic [63:0] r = h;
    r[63:56] = 8'hFF;
    if (rq) r[15:8] = fl ? 8'h01 : 8'h00;
    return r;
  endfunction

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!irq_done && !irq_err && !wb_valid && !halted && desc_ready, "R1",
        {59'd0, irq_done, irq_err, wb_valid, halted, desc_ready}, 64'd1);

    for (int i = 0; i < 14; i++) begin
      logic [13:0] v = VEC[i];
      logic [63:0] h = 64'h1122_3344_5566_A500 ^ (64'(i) << 24);
      h[0] = v[7];
      {cfg_done_irq, cfg_irq_all, cfg_icv_irq, cfg_wb_en, cfg_wb_all, cfg_halt} = v[13:8];
      hdr_in = h; icv_req = v[6]; icv_fail = v[5];
      err_evt = v[4]; desc_done = ~v[4];
      @(negedge clk);
      err_evt = 0; desc_done = 0;
      chk(irq_done == v[3], "R2 done irq", 64'(irq_done), 64'(v[3]));
      chk(irq_err == v[2], "R6/R7 err irq", 64'(irq_err), 64'(v[2]));
      chk(wb_valid == v[1], "R4 writeback", 64'(wb_valid), 64'(v[1]));
      chk(halted == v[0], "R8 halt", 64'(halted), 64'(v[0]));
      if (v[1]) begin
        chk(wb_data == expect_wb(h, v[6], v[5]), "R3 data", wb_data, expect_wb(h, v[6], v[5]));
        hdr_in = ~h;
        @(negedge clk);
        chk(wb_valid && !desc_ready && wb_data == expect_wb(h, v[6], v[5]), "R5 hold",
            wb_data, expect_wb(h, v[6], v[5]));
        wb_ready = 1;
        @(negedge clk);
        wb_ready = 0;
        chk(!wb_valid && desc_ready, "R5 release", 64'(wb_valid), 64'd0);
      end
      if (v[0]) begin
        @(negedge clk);
        chk(halted && !desc_ready, "R8 stays halted", 64'(halted), 64'd1);
        host_resume = 1;
        @(negedge clk);
        host_resume = 0;
        chk(!halted && desc_ready, "R8 resume", 64'(halted), 64'd0);
      end
      host_ack_done = 1; host_ack_err = 1;
      @(negedge clk);
      host_ack_done = 0; host_ack_err = 0;
      chk(!irq_done && !irq_err, "R9 ack", {62'd0, irq_done, irq_err}, 64'd0);
    end

    // R9: level holds, set wins over ack in same cycle
    {cfg_done_irq, cfg_irq_all, cfg_icv_irq, cfg_wb_en, cfg_wb_all, cfg_halt} = 6'b110000;
    desc_done = 1; icv_req = 0; icv_fail = 0;
    @(negedge clk);
    desc_done = 0;
    repeat (3) @(negedge clk);
    chk(irq_done, "R9 level", 64'(irq_done), 64'd1);
    desc_done = 1; host_ack_done = 1;
    @(negedge clk);
    desc_done = 0; host_ack_done = 0;
    chk(irq_done, "R9 set wins", 64'(irq_done), 64'd1);
    host_ack_done = 1;
    @(negedge clk);
    host_ack_done = 0;

    // R10: events ignored while halted
    {cfg_done_irq, cfg_irq_all, cfg_icv_irq, cfg_wb_en, cfg_wb_all, cfg_halt} = 6'b110111;
    err_evt = 1;
    @(negedge clk);
    err_evt = 0; host_ack_err = 1;
    @(negedge clk);
    host_ack_err = 0;
    desc_done = 1; err_evt = 1;
    @(negedge clk);
    desc_done = 0; err_evt = 0;
    chk(!irq_done && !irq_err && !wb_valid && halted, "R10 halted ignore",
        {60'd0, irq_done, irq_err, wb_valid, halted}, 64'd1);
    host_resume = 1;
    @(negedge clk);
    host_resume = 0;

    // R6: error beats simultaneous done
    desc_done = 1; err_evt = 1; cfg_halt = 0;
    @(negedge clk);
    desc_done = 0; err_evt = 0;
    chk(irq_err && !irq_done && !wb_valid && desc_ready, "R6 priority",
        {61'd0, irq_err, irq_done, wb_valid}, 64'd4);
    host_ack_err = 1;
    @(negedge clk);
    host_ack_err = 0;

    // R10: resume while not halted
    host_resume = 1;
    @(negedge clk);
    host_resume = 0;
    chk(desc_ready && !halted && !wb_valid, "R10 resume idle", 64'(halted), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule